// File: doc/BRIEF.md
# Triangle Tile Binning Unit

This block sits after geometry processing and before rasterization in a sort-middle renderer. Each incoming triangle is already in screen space. It arrives as an index plus a pixel bounding box. The block works out which screen tiles that box overlaps and appends the index to the list of every such tile. The lists are kept in on-chip storage, and a triangle that spans several tiles is copied into each of their lists.

An end-of-frame beat closes binning. Until that beat is accepted, the raster-side port stays silent. After it, the block hands the lists out one tile at a time in row-major tile order. Each beat carries the tile coordinates and marks the first and last entry of the tile. A tile with no triangles still produces one marker beat. When the final tile has gone out, every list is emptied and the next frame may begin.

Default geometry: 16x16-pixel tiles on a 128x128 screen, an 8x8 grid, and a capacity of four indices per tile list.

Top module: `tile_binner`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and overflow is 0.
- R2: A triangle with in_x0<=in_x1 and in_y0<=in_y1 is appended to every tile (tx,ty) with min(in_x0>>4,7)<=tx<=min(in_x1>>4,7) and min(in_y0>>4,7)<=ty<=min(in_y1>>4,7). Coordinates beyond the screen are clamped to the last tile column or row.
- R3: out_valid stays 0 until a beat with in_eof=1 has been accepted. in_ready is 0 while a triangle is being spread over its tiles and during the whole output phase.
- R4: Tiles are output in ascending order of tile number ty*8+tx, reported on out_tile_x/out_tile_y. All beats of one tile are output before any beat of the next tile.
- R5: Within one tile, indices appear on out_idx in the order the triangles were accepted.
- R6: out_first is 1 on the first beat of a tile and out_last is 1 on its last beat. A tile with an empty list gives exactly one beat with out_empty=1, out_first=1, out_last=1 and out_idx=0. Every other beat has out_empty=0.
- R7: Each tile list holds at most 4 indices. An append to a full list is dropped and sets overflow, which stays 1 until reset.
- R8: After the last beat of tile (7,7) is accepted, all lists are empty and in_ready returns to 1. A following frame without triangles therefore yields 64 empty-tile beats.
- R9: While out_valid=1 and out_ready=0, all out_* fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take an input beat |
| in_eof | input | 1 | Beat is the end-of-frame marker, not a triangle |
| in_idx | input | 8 | Triangle index |
| in_x0 | input | 8 | Bounding box left pixel |
| in_y0 | input | 8 | Bounding box top pixel |
| in_x1 | input | 8 | Bounding box right pixel |
| in_y1 | input | 8 | Bounding box bottom pixel |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Raster side accepts the beat |
| out_tile_x | output | 3 | Tile column |
| out_tile_y | output | 3 | Tile row |
| out_idx | output | 8 | Triangle index (0 for an empty tile) |
| out_empty | output | 1 | Beat stands for an empty tile |
| out_first | output | 1 | First beat of the tile |
| out_last | output | 1 | Last beat of the tile |
| overflow | output | 1 | Sticky: some append was dropped |

## Verification
Some properties are checked on every cycle: that input acceptance and output never overlap, that a stalled output beat holds still, that a tile does not change in the middle of its list, that an empty-tile beat carries both markers, and that overflow never falls. Other behaviour can only be shown by the bench's scenarios against its queue-based model. That covers the exact set of tiles a bounding box maps to, including clamping, and the submission order within a list. It also covers dropping at capacity, and the clearing of lists between frames, which shows up as a frame made only of empty-tile beats.

// File: rtl/tbin_pkg.sv
package tbin_pkg;
    typedef enum logic [1:0] {
        ST_ACCEPT = 2'd0,
        ST_BIN    = 2'd1,
        ST_DRAIN  = 2'd2
    } tbin_state_e;
endpackage

// File: rtl/tbin_tile_range.sv
module tbin_tile_range #(
    parameter int COORD_W    = 8,
    parameter int TILE_SHIFT = 4,
    parameter int GRID_N     = 8,
    localparam int TW        = $clog2(GRID_N)
) (
    input  logic [COORD_W-1:0] lo_px,
    input  logic [COORD_W-1:0] hi_px,
    output logic [TW-1:0]      lo_t,
    output logic [TW-1:0]      hi_t
);
    localparam logic [COORD_W-1:0] LAST = COORD_W'(GRID_N - 1);

    logic [COORD_W-1:0] lo_s, hi_s;

    always_comb begin
        lo_s = lo_px >> TILE_SHIFT;
        hi_s = hi_px >> TILE_SHIFT;
        lo_t = (lo_s > LAST) ? TW'(GRID_N - 1) : lo_s[TW-1:0];
        hi_t = (hi_s > LAST) ? TW'(GRID_N - 1) : hi_s[TW-1:0];
    end
endmodule

// File: rtl/tbin_list_store.sv
module tbin_list_store #(
    parameter int TILES  = 64,
    parameter int DEPTH  = 4,
    parameter int IDX_W  = 8,
    localparam int TIW   = $clog2(TILES),
    localparam int EW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             app_en,
    input  logic [TIW-1:0]   app_tile,
    input  logic [IDX_W-1:0] app_idx,
    output logic             app_full,
    input  logic [TIW-1:0]   rd_tile,
    input  logic [EW-1:0]    rd_entry,
    output logic [IDX_W-1:0] rd_idx,
    output logic [CW-1:0]    rd_count
);
    logic [CW-1:0]    cnt_d [TILES];
    logic [CW-1:0]    cnt_q [TILES];
    logic [IDX_W-1:0] mem_d [TILES][DEPTH];
    logic [IDX_W-1:0] mem_q [TILES][DEPTH];

    assign app_full = (cnt_q[app_tile] == CW'(DEPTH));
    assign rd_count = cnt_q[rd_tile];
    assign rd_idx   = mem_q[rd_tile][rd_entry];

    always_comb begin
        cnt_d = cnt_q;
        mem_d = mem_q;
        if (clr) begin
            for (int t = 0; t < TILES; t++) cnt_d[t] = '0;
        end else if (app_en && !app_full) begin
            mem_d[app_tile][cnt_q[app_tile][EW-1:0]] = app_idx;
            cnt_d[app_tile] = cnt_q[app_tile] + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < TILES; t++) cnt_q[t] <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end
endmodule

// File: rtl/tile_binner.sv
module tile_binner
    import tbin_pkg::*;
#(
    parameter int COORD_W    = 8,
    parameter int IDX_W      = 8,
    parameter int TILE_SHIFT = 4,
    parameter int GRID_W     = 8,
    parameter int GRID_H     = 8,
    parameter int LIST_DEPTH = 4,
    localparam int TXW       = $clog2(GRID_W),
    localparam int TYW       = $clog2(GRID_H)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               in_eof,
    input  logic [IDX_W-1:0]   in_idx,
    input  logic [COORD_W-1:0] in_x0,
    input  logic [COORD_W-1:0] in_y0,
    input  logic [COORD_W-1:0] in_x1,
    input  logic [COORD_W-1:0] in_y1,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [TXW-1:0]     out_tile_x,
    output logic [TYW-1:0]     out_tile_y,
    output logic [IDX_W-1:0]   out_idx,
    output logic               out_empty,
    output logic               out_first,
    output logic               out_last,
    output logic               overflow
);
    localparam int TILES = GRID_W * GRID_H;
    localparam int TIW   = $clog2(TILES);
    localparam int EW    = $clog2(LIST_DEPTH);
    localparam int CW    = $clog2(LIST_DEPTH + 1);

    typedef struct packed {
        tbin_state_e      st;
        logic [TXW-1:0]   cx;
        logic [TXW-1:0]   x_lo;
        logic [TXW-1:0]   x_hi;
        logic [TYW-1:0]   cy;
        logic [TYW-1:0]   y_hi;
        logic [IDX_W-1:0] idx;
        logic [TIW-1:0]   dtile;
        logic [EW-1:0]    dent;
        logic             ovf;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic [TXW-1:0]   bx_lo, bx_hi;
    logic [TYW-1:0]   by_lo, by_hi;
    logic             app_en, app_full, clr;
    logic [TIW-1:0]   app_tile;
    logic [IDX_W-1:0] rd_idx;
    logic [CW-1:0]    rd_count;
    logic             tile_empty, last_entry;

    tbin_tile_range #(.COORD_W(COORD_W), .TILE_SHIFT(TILE_SHIFT), .GRID_N(GRID_W)) x_rng_i (
        .lo_px(in_x0), .hi_px(in_x1), .lo_t(bx_lo), .hi_t(bx_hi));
    tbin_tile_range #(.COORD_W(COORD_W), .TILE_SHIFT(TILE_SHIFT), .GRID_N(GRID_H)) y_rng_i (
        .lo_px(in_y0), .hi_px(in_y1), .lo_t(by_lo), .hi_t(by_hi));

    tbin_list_store #(.TILES(TILES), .DEPTH(LIST_DEPTH), .IDX_W(IDX_W)) store_i (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .app_en(app_en), .app_tile(app_tile), .app_idx(c_q.idx), .app_full(app_full),
        .rd_tile(c_q.dtile), .rd_entry(c_q.dent), .rd_idx(rd_idx), .rd_count(rd_count));

    assign app_tile   = TIW'(c_q.cy) * TIW'(GRID_W) + TIW'(c_q.cx);
    assign tile_empty = (rd_count == '0);
    assign last_entry = tile_empty || ((CW'(c_q.dent) + CW'(1)) == rd_count);

    assign in_ready   = (c_q.st == ST_ACCEPT);
    assign out_valid  = (c_q.st == ST_DRAIN);
    assign out_tile_x = TXW'(c_q.dtile % TIW'(GRID_W));
    assign out_tile_y = TYW'(c_q.dtile / TIW'(GRID_W));
    assign out_idx    = tile_empty ? '0 : rd_idx;
    assign out_empty  = tile_empty;
    assign out_first  = (c_q.dent == '0);
    assign out_last   = last_entry;
    assign overflow   = c_q.ovf;

    always_comb begin
        c_d    = c_q;
        app_en = 1'b0;
        clr    = 1'b0;
        case (c_q.st)
            ST_ACCEPT: begin
                if (in_valid) begin
                    if (in_eof) begin
                        c_d.st    = ST_DRAIN;
                        c_d.dtile = '0;
                        c_d.dent  = '0;
                    end else begin
                        c_d.st   = ST_BIN;
                        c_d.idx  = in_idx;
                        c_d.x_lo = bx_lo;
                        c_d.x_hi = bx_hi;
                        c_d.y_hi = by_hi;
                        c_d.cx   = bx_lo;
                        c_d.cy   = by_lo;
                    end
                end
            end
            ST_BIN: begin
                app_en = 1'b1;
                if (app_full) c_d.ovf = 1'b1;
                if (c_q.cx == c_q.x_hi) begin
                    c_d.cx = c_q.x_lo;
                    if (c_q.cy == c_q.y_hi) c_d.st = ST_ACCEPT;
                    else                    c_d.cy = c_q.cy + TYW'(1);
                end else begin
                    c_d.cx = c_q.cx + TXW'(1);
                end
            end
            ST_DRAIN: begin
                if (out_ready) begin
                    if (last_entry) begin
                        c_d.dent = '0;
                        if (c_q.dtile == TIW'(TILES - 1)) begin
                            c_d.st    = ST_ACCEPT;
                            c_d.dtile = '0;
                            clr       = 1'b1;
                        end else begin
                            c_d.dtile = c_q.dtile + TIW'(1);
                        end
                    end else begin
                        c_d.dent = c_q.dent + EW'(1);
                    end
                end
            end
            default: c_d.st = ST_ACCEPT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_ACCEPT;
        end else begin
            c_q <= c_d;
        end
    end

    // R3
    idle_while_binning_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_idx) && $stable(out_tile_x)
        && $stable(out_tile_y) && $stable(out_first) && $stable(out_last) && $stable(out_empty));

    // R4
    tile_no_interleave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !out_last |=> out_valid && $stable(out_tile_x) && $stable(out_tile_y));

    // R6
    empty_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_empty |-> out_first && out_last && (out_idx == '0));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

// File: tb/tile_binner_tb.sv
`timescale 1ns/1ps
module tile_binner_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_eof = 1'b0, out_ready = 1'b0;
    logic [7:0] in_idx = '0, in_x0 = '0, in_y0 = '0, in_x1 = '0, in_y1 = '0;
    logic       in_ready, out_valid, out_empty, out_first, out_last, overflow;
    logic [2:0] out_tile_x, out_tile_y;
    logic [7:0] out_idx;

    always #10 clk = ~clk;

    tile_binner dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_eof(in_eof),
        .in_idx(in_idx), .in_x0(in_x0), .in_y0(in_y0), .in_x1(in_x1), .in_y1(in_y1),
        .out_valid(out_valid), .out_ready(out_ready), .out_tile_x(out_tile_x),
        .out_tile_y(out_tile_y), .out_idx(out_idx), .out_empty(out_empty),
        .out_first(out_first), .out_last(out_last), .overflow(overflow));

    typedef struct { int tx; int ty; int idx; bit e; bit f; bit l; } beat_t;

    int    n_chk = 0, n_fail = 0, cyc = 0;
    int    mq[64][$];
    beat_t exp_q[$];
    bit    ovf_m = 0, ready_all = 0, prev_stall = 0, done = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [18:0] prev_fields;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int clampt(input int px);
        return ((px >> 4) > 7) ? 7 : (px >> 4);
    endfunction

    task automatic wait_accept();
        forever begin
            if (in_ready) begin
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_eof   = 1'b0;
    endtask

    task automatic send_tri(input int idx, input int x0, input int y0, input int x1, input int y1);
        in_valid = 1'b1; in_eof = 1'b0; in_idx = 8'(idx);
        in_x0 = 8'(x0); in_y0 = 8'(y0); in_x1 = 8'(x1); in_y1 = 8'(y1);
        wait_accept();
        for (int ty = clampt(y0); ty <= clampt(y1); ty++)
            for (int tx = clampt(x0); tx <= clampt(x1); tx++) begin
                if (mq[ty*8+tx].size() < 4) mq[ty*8+tx].push_back(idx);
                else ovf_m = 1;
            end
    endtask

    task automatic send_eof();
        in_valid = 1'b1; in_eof = 1'b1;
        wait_accept();
        chk(overflow == ovf_m, "R7 overflow flag", int'(overflow), int'(ovf_m));
        for (int t = 0; t < 64; t++) begin
            if (mq[t].size() == 0) begin
                exp_q.push_back('{t % 8, t / 8, 0, 1'b1, 1'b1, 1'b1});
            end else begin
                for (int k = 0; k < mq[t].size(); k++)
                    exp_q.push_back('{t % 8, t / 8, mq[t][k], 1'b0, k == 0, k == mq[t].size() - 1});
            end
            mq[t].delete();
        end
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        chk(in_ready == 1'b1, "R8 ready after last tile", int'(in_ready), 1);
    endtask

    // cycle-by-cycle comparison against the model
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && !done) begin
                cyc++;
                chk(out_valid == (exp_q.size() != 0), "R3 output idle until frame end",
                    int'(out_valid), int'(exp_q.size() != 0));
                if (prev_stall)
                    chk({out_tile_x, out_tile_y, out_idx, out_empty, out_first, out_last} == prev_fields,
                        "R9 hold while stalled", int'({out_tile_x, out_tile_y, out_idx}), int'(prev_fields[18:3]));
                if (out_valid && exp_q.size() != 0) begin
                    chk(int'(out_tile_x) == exp_q[0].tx && int'(out_tile_y) == exp_q[0].ty,
                        "R4 tile order", int'(out_tile_y) * 8 + int'(out_tile_x), exp_q[0].ty * 8 + exp_q[0].tx);
                    chk(int'(out_idx) == exp_q[0].idx, "R2/R5 list content and order",
                        int'(out_idx), exp_q[0].idx);
                    chk(out_empty == exp_q[0].e && out_first == exp_q[0].f && out_last == exp_q[0].l,
                        "R6/R8 markers and empty beat", int'({out_empty, out_first, out_last}),
                        int'({exp_q[0].e, exp_q[0].f, exp_q[0].l}));
                end
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                out_ready   = ready_all | lfsr[0] | lfsr[3];
                prev_stall  = out_valid && !out_ready;
                prev_fields = {out_tile_x, out_tile_y, out_idx, out_empty, out_first, out_last};
                if (out_valid && out_ready && exp_q.size() != 0) void'(exp_q.pop_front());
                if (cyc > 100000) begin
                    n_chk++; n_fail++;
                    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
                    done = 1;
                    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                    $finish;
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
        chk(overflow == 1'b0, "R1 reset overflow", int'(overflow), 0);
        @(negedge clk);
        // frame 1: single tile, multi tile, clamped, full screen
        send_tri(1, 5, 5, 10, 10);
        send_tri(2, 20, 3, 40, 20);
        send_tri(3, 100, 100, 250, 200);
        send_tri(4, 0, 0, 127, 127);
        send_tri(5, 16, 16, 16, 16);
        send_eof();
        // frame 2: no triangles, every tile empty (R8 clearing)
        ready_all = 1;
        send_eof();
        ready_all = 0;
        // frame 3: capacity exceeded on tile 0 (R7)
        for (int i = 10; i < 16; i++) send_tri(i, 1, 1, 2, 2);
        send_tri(20, 120, 0, 127, 5);
        send_eof();
        // frame 4: lists start empty again, overflow stays set
        send_tri(30, 50, 60, 70, 70);
        send_tri(31, 127, 127, 127, 127);
        send_eof();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule